// File: doc/BRIEF.md
# Frequency ID Override Mux

This block sits between the processor socket and the clock logic of a board controller. It takes a 4-bit frequency-ID code from the processor's input pins and drives it out on two 4-bit groups, one back toward the processor and one toward the chipset. In the default mode the input code reaches both groups unchanged and without delay. When software sets an override enable bit, each group instead takes a value that software has stored in a register of its own. This lets the two sides be set to different ratios from the ones the processor straps.

The two override values live in different reset domains. The processor-side value and the enable bit belong to the standby domain. They are also cleared by the board reset output and by the fitting of a new processor. The chipset-side value is cleared only by the battery-domain reset, so it survives everything else. The block watches an active-low slot-occupied input and flags a newly fitted processor in a sticky status bit that software clears. All of this is reached through a simple synchronous byte-address register port with a write strobe and a combinational read.

Top module: `fid_override_mux`

## Requirements
- R1: While the override enable (register 02h bit 4) is 0, both `cpu_fid_o` and `cs_fid_o` equal `fid_in`, combinationally.
- R2: While the override enable is 1, `cpu_fid_o` equals register 02h bits 3:0 and `cs_fid_o` equals register 03h bits 3:0. A register write changes the outputs from the clock edge that performs it.
- R3: Register 02h reads {000, enable, cpu value}. Register 03h reads {0000, chipset value}. Register 05h reads {status, 0000000}, so its clear bit 6 always reads 0. Any other address reads 00h and ignores writes.
- R4: Standby reset (`sb_rst_n` low) clears register 02h and the new-processor status. It leaves register 03h unchanged.
- R5: Battery reset (`bat_rst_n` low) clears register 03h. It leaves register 02h unchanged.
- R6: A clock edge with `rstout_n` low clears register 02h, even when a write to 02h occurs at the same edge. Register 03h is unchanged.
- R7: A high-to-low transition of `slot_occ_n` is a new-processor event. It passes through two synchronising flops, so status bit 7 of 05h becomes 1 at the third rising edge after the new level is applied. At that same edge register 02h is cleared. Register 03h keeps its value.
- R8: Writing 05h with bit 6 = 1 clears the status at that edge. Writing 05h with bit 6 = 0 leaves the status unchanged.
- R9: When a new-processor event and a status clear happen at the same edge, the status ends set.
- R10: A low-to-high transition of `slot_occ_n` sets no status and clears no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| sb_rst_n | input | 1 | Standby-power reset, active low, asynchronous assert |
| bat_rst_n | input | 1 | Battery-domain reset, active low, asynchronous assert |
| rstout_n | input | 1 | Board reset output level, active low, synchronous to clk |
| slot_occ_n | input | 1 | Processor slot occupied, active low, asynchronous |
| fid_in | input | 4 | Frequency-ID code from the processor |
| cpu_fid_o | output | 4 | Frequency-ID code toward the processor |
| cs_fid_o | output | 4 | Frequency-ID code toward the chipset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one write per clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |

## Verification
The assertions assume three things about the inputs:
- The register port and `rstout_n` are synchronous to `clk`.
- Each level of `slot_occ_n` lasts long enough to cross both synchronising flops, so each transition yields exactly one single-cycle event.
- Each reset is held low long enough for its synchroniser to flush.

The stimulus changes every input on the falling clock edge. It holds every slot level for at least four cycles and holds each reset low for several cycles. Random register traffic and `rstout_n` pulses are generated only while the slot input is steady, which keeps the status model exact.

// File: rtl/fid_pkg.sv
package fid_pkg;

  localparam int unsigned FID_W_DEF  = 4;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned ADDR_W_DEF = 8;

  // Register offsets
  localparam logic [7:0] OFS_CPU_CTL = 8'h02;
  localparam logic [7:0] OFS_CS_VAL  = 8'h03;
  localparam logic [7:0] OFS_SLOT_ST = 8'h05;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_CPU  = 2'd1,
    RSEL_CS   = 2'd2,
    RSEL_STAT = 2'd3
  } fid_rsel_e;

endpackage

// File: rtl/fid_rst_sync.sv
module fid_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_sync_no = pipe_q[STAGES-1];

endmodule

// File: rtl/fid_slot_detect.sv
module fid_slot_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic slot_occ_ni,
  input  logic clr_req_i,
  output logic new_cpu_evt_o,
  output logic status_o
);

  // Reset value 0 means "occupied": no event fires on power-up.
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   status_q;
  logic                   status_d;
  logic                   slot_lvl;
  logic                   evt;

  assign slot_lvl = sync_q[SYNC_STAGES-1];
  // Falling edge: was empty (1), now occupied (0)
  assign evt      = prev_q & ~slot_lvl;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], slot_occ_ni};
    prev_d = slot_lvl;
    status_d = status_q;
    if (evt) begin
      status_d = 1'b1;
    end else if (clr_req_i) begin
      status_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      sync_q   <= sync_d;
      prev_q   <= prev_d;
      status_q <= status_d;
    end
  end

  assign new_cpu_evt_o = evt;
  assign status_o      = status_q;

  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_ni)
    evt |=> status_q); // R9

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_req_i && !evt) |=> !status_q); // R8

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    evt |=> !evt); // R7

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_ni)
    (!evt && !status_q) |=> !status_q); // R10

endmodule

// File: rtl/fid_regfile.sv
module fid_regfile
  import fid_pkg::*;
#(
  parameter int unsigned FID_W  = FID_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              sb_rst_ni,
  input  logic              bat_rst_ni,
  input  logic              rstout_ni,
  input  logic              new_cpu_evt_i,
  input  logic              status_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clr_req_o,
  output logic              ovr_en_o,
  output logic [FID_W-1:0]  cpu_val_o,
  output logic [FID_W-1:0]  cs_val_o
);

  localparam int unsigned EN_BIT   = FID_W;
  localparam int unsigned STAT_BIT = DATA_W - 1;
  localparam int unsigned CLR_BIT  = DATA_W - 2;

  localparam logic [ADDR_W-1:0] A_CPU  = ADDR_W'(OFS_CPU_CTL);
  localparam logic [ADDR_W-1:0] A_CS   = ADDR_W'(OFS_CS_VAL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_SLOT_ST);

  fid_rsel_e        rsel;
  logic             cpu_we;
  logic             cs_we;
  logic             cpu_clr;
  logic             en_q,  en_d;
  logic [FID_W-1:0] cpu_q, cpu_d;
  logic [FID_W-1:0] cs_q,  cs_d;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  // Address decode
  always_comb begin
    unique case (addr_i)
      A_CPU:   rsel = RSEL_CPU;
      A_CS:    rsel = RSEL_CS;
      A_STAT:  rsel = RSEL_STAT;
      default: rsel = RSEL_NONE;
    endcase
  end

  assign cpu_we    = wr_i && (rsel == RSEL_CPU);
  assign cs_we     = wr_i && (rsel == RSEL_CS);
  assign clr_req_o = wr_i && (rsel == RSEL_STAT) && wdata_i[CLR_BIT];
  assign cpu_clr   = !rstout_ni || new_cpu_evt_i;

  // Next state: clears take priority over writes
  always_comb begin
    en_d  = en_q;
    cpu_d = cpu_q;
    if (cpu_clr) begin
      en_d  = 1'b0;
      cpu_d = '0;
    end else if (cpu_we) begin
      en_d  = wdata_i[EN_BIT];
      cpu_d = wdata_i[FID_W-1:0];
    end
  end

  always_comb begin
    cs_d = cs_q;
    if (cs_we) begin
      cs_d = wdata_i[FID_W-1:0];
    end
  end

  // Standby domain
  always_ff @(posedge clk or negedge sb_rst_ni) begin
    if (!sb_rst_ni) begin
      en_q  <= 1'b0;
      cpu_q <= '0;
    end else begin
      en_q  <= en_d;
      cpu_q <= cpu_d;
    end
  end

  // Battery domain
  always_ff @(posedge clk or negedge bat_rst_ni) begin
    if (!bat_rst_ni) begin
      cs_q <= '0;
    end else begin
      cs_q <= cs_d;
    end
  end

  // Read mux
  always_comb begin
    rdata_o = '0;
    unique case (rsel)
      RSEL_CPU: begin
        rdata_o[FID_W-1:0] = cpu_q;
        rdata_o[EN_BIT]    = en_q;
      end
      RSEL_CS:   rdata_o[FID_W-1:0] = cs_q;
      RSEL_STAT: rdata_o[STAT_BIT]  = status_i;
      default:   rdata_o = '0;
    endcase
  end

  assign ovr_en_o  = en_q;
  assign cpu_val_o = cpu_q;
  assign cs_val_o  = cs_q;

  AST_CPU_CLR_ON_EVENT: assert property (@(posedge clk) disable iff (!sb_rst_ni)
    new_cpu_evt_i |=> (!en_q && cpu_q == '0)); // R7

  AST_CPU_CLR_ON_RSTOUT: assert property (@(posedge clk) disable iff (!sb_rst_ni)
    !rstout_ni |=> (!en_q && cpu_q == '0)); // R6

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!bat_rst_ni)
    !cs_we |=> $stable(cs_q)); // R5

endmodule

// File: rtl/fid_out_mux.sv
module fid_out_mux #(
  parameter int unsigned FID_W  = 4,
  parameter int unsigned GROUPS = 2
) (
  input  logic                         ovr_en_i,
  input  logic [FID_W-1:0]             fid_in_i,
  input  logic [GROUPS-1:0][FID_W-1:0] ovr_val_i,
  output logic [GROUPS-1:0][FID_W-1:0] fid_o
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_comb begin
      if (ovr_en_i) begin
        fid_o[g] = ovr_val_i[g];
      end else begin
        fid_o[g] = fid_in_i;
      end
    end
  end

endmodule

// File: rtl/fid_override_mux.sv
module fid_override_mux
  import fid_pkg::*;
#(
  parameter int unsigned FID_W       = FID_W_DEF,
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              sb_rst_n,
  input  logic              bat_rst_n,
  input  logic              rstout_n,
  input  logic              slot_occ_n,
  input  logic [FID_W-1:0]  fid_in,
  output logic [FID_W-1:0]  cpu_fid_o,
  output logic [FID_W-1:0]  cs_fid_o,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int unsigned N_RST   = 2;
  localparam int unsigned IDX_SB  = 0;
  localparam int unsigned IDX_BAT = 1;
  localparam int unsigned GROUPS  = 2;
  localparam int unsigned G_CPU   = 0;
  localparam int unsigned G_CS    = 1;

  logic [N_RST-1:0]             rst_raw;
  logic [N_RST-1:0]             rst_syn;
  logic                         new_cpu_evt;
  logic                         status;
  logic                         clr_req;
  logic                         ovr_en;
  logic [FID_W-1:0]             cpu_val;
  logic [FID_W-1:0]             cs_val;
  logic [GROUPS-1:0][FID_W-1:0] ovr_vals;
  logic [GROUPS-1:0][FID_W-1:0] mux_out;

  assign rst_raw[IDX_SB]  = sb_rst_n;
  assign rst_raw[IDX_BAT] = bat_rst_n;

  for (genvar r = 0; r < N_RST; r++) begin : g_rst
    fid_rst_sync #(.STAGES(RST_STAGES)) u_sync (
      .clk        (clk),
      .rst_ni     (rst_raw[r]),
      .rst_sync_no(rst_syn[r])
    );
  end

  fid_slot_detect #(.SYNC_STAGES(SYNC_STAGES)) u_slot (
    .clk          (clk),
    .rst_ni       (rst_syn[IDX_SB]),
    .slot_occ_ni  (slot_occ_n),
    .clr_req_i    (clr_req),
    .new_cpu_evt_o(new_cpu_evt),
    .status_o     (status)
  );

  fid_regfile #(.FID_W(FID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .sb_rst_ni    (rst_syn[IDX_SB]),
    .bat_rst_ni   (rst_syn[IDX_BAT]),
    .rstout_ni    (rstout_n),
    .new_cpu_evt_i(new_cpu_evt),
    .status_i     (status),
    .addr_i       (reg_addr),
    .wr_i         (reg_wr),
    .wdata_i      (reg_wdata),
    .rdata_o      (reg_rdata),
    .clr_req_o    (clr_req),
    .ovr_en_o     (ovr_en),
    .cpu_val_o    (cpu_val),
    .cs_val_o     (cs_val)
  );

  assign ovr_vals[G_CPU] = cpu_val;
  assign ovr_vals[G_CS]  = cs_val;

  fid_out_mux #(.FID_W(FID_W), .GROUPS(GROUPS)) u_mux (
    .ovr_en_i (ovr_en),
    .fid_in_i (fid_in),
    .ovr_val_i(ovr_vals),
    .fid_o    (mux_out)
  );

  assign cpu_fid_o = mux_out[G_CPU];
  assign cs_fid_o  = mux_out[G_CS];

  AST_STAT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_syn[IDX_SB])
    (reg_addr == ADDR_W'(OFS_SLOT_ST)) |-> (reg_rdata[DATA_W-2:0] == '0)); // R3

  AST_PASS_BOTH: assert property (@(posedge clk) disable iff (!rst_syn[IDX_SB])
    !ovr_en |-> (cpu_fid_o == fid_in && cs_fid_o == fid_in)); // R1

endmodule

// File: tb/tb_fid_override_mux.sv
module tb_fid_override_mux;

  logic       clk = 1'b0;
  logic       sb_rst_n, bat_rst_n, rstout_n, slot_occ_n;
  logic [3:0] fid_in;
  logic [3:0] cpu_fid_o, cs_fid_o;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Bench model of the register state
  logic       m_en;
  logic [3:0] m_cpu, m_cs;
  logic       m_st;

  always #4 clk = ~clk;

  fid_override_mux dut (
    .clk(clk), .sb_rst_n(sb_rst_n), .bat_rst_n(bat_rst_n), .rstout_n(rstout_n),
    .slot_occ_n(slot_occ_n), .fid_in(fid_in), .cpu_fid_o(cpu_fid_o),
    .cs_fid_o(cs_fid_o), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h02:   return {3'b000, m_en, m_cpu};
      8'h03:   return {4'b0000, m_cs};
      8'h05:   return {m_st, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] exp_cpu_out();
    return m_en ? m_cpu : fid_in;
  endfunction

  function automatic logic [3:0] exp_cs_out();
    return m_en ? m_cs : fid_in;
  endfunction

  // All tasks start and end at a falling edge
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    logic [7:0] d;
    rd(8'h02, d); chk(req, d, exp_read(8'h02));
    rd(8'h03, d); chk(req, d, exp_read(8'h03));
    rd(8'h05, d); chk(req, d, exp_read(8'h05));
  endtask

  task automatic check_outs(input string req);
    #1;
    chk(req, {4'h0, cpu_fid_o}, {4'h0, exp_cpu_out()});
    chk(req, {4'h0, cs_fid_o},  {4'h0, exp_cs_out()});
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=%0d expected=<200000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin : main
    logic [7:0] d;
    void'($urandom(32'h5EED_F1D0));
    sb_rst_n = 0; bat_rst_n = 0; rstout_n = 1; slot_occ_n = 0;
    fid_in = 4'h9; reg_addr = 0; reg_wdata = 0; reg_wr = 0;
    m_en = 0; m_cpu = 0; m_cs = 0; m_st = 0;
    idle(4);
    sb_rst_n = 1; bat_rst_n = 1;
    idle(4);

    // Reset state and passthrough
    check_regs("R4 reset state");
    check_outs("R1 passthrough after reset");
    fid_in = 4'h6; check_outs("R1 passthrough follows input");

    // Override and reserved bits
    wr(8'h03, 8'hA5); m_cs = 4'h5;
    check_regs("R3 chipset reserved bits");
    wr(8'h02, 8'hFF); m_en = 1; m_cpu = 4'hF;
    check_outs("R2 override outputs at write edge");
    check_regs("R3 cpu control reserved bits");
    wr(8'h05, 8'hFF); rd(8'h05, d); chk("R3 clear bit reads 0", d, 8'h00);
    wr(8'h07, 8'hFF); rd(8'h07, d); chk("R3 undecoded address", d, 8'h00);
    check_regs("R3 undecoded write ignored");

    // Reset output, with a colliding write
    reg_addr = 8'h02; reg_wdata = 8'h1C; reg_wr = 1; rstout_n = 0;
    @(posedge clk); @(negedge clk);
    reg_wr = 0; rstout_n = 1; m_en = 0; m_cpu = 0;
    check_regs("R6 reset output clears cpu, wins over write");
    check_outs("R6 outputs back to passthrough");

    // Standby reset keeps chipset value
    wr(8'h02, 8'h1A); m_en = 1; m_cpu = 4'hA;
    sb_rst_n = 0; idle(3); sb_rst_n = 1; idle(3);
    m_en = 0; m_cpu = 0;
    check_regs("R4 standby reset keeps chipset value");

    // Battery reset keeps cpu value
    wr(8'h02, 8'h13); m_en = 1; m_cpu = 4'h3;
    bat_rst_n = 0; idle(3); bat_rst_n = 1; idle(3);
    m_cs = 0;
    check_regs("R5 battery reset clears only chipset");
    wr(8'h03, 8'h07); m_cs = 4'h7;
    check_outs("R2 override after battery reset");

    // Slot removal: no event
    slot_occ_n = 1; idle(5);
    check_regs("R10 rising slot input has no effect");

    // Slot insertion: event timing
    slot_occ_n = 0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rd(8'h05, d); chk("R7 status not yet set after two edges", d, 8'h00);
    @(posedge clk); @(negedge clk);
    m_st = 1; m_en = 0; m_cpu = 0;
    check_regs("R7 status set and cpu cleared at third edge");
    check_outs("R7 outputs passthrough after new cpu");

    // Clear behaviour
    wr(8'h05, 8'hBF); check_regs("R8 write without clear bit keeps status");
    wr(8'h05, 8'h40); m_st = 0; check_regs("R8 clear bit clears status");

    // Event and clear in the same cycle
    slot_occ_n = 1; idle(5);
    slot_occ_n = 0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr(8'h05, 8'h40); m_st = 1;
    check_regs("R9 event wins over clear");
    wr(8'h05, 8'h40); m_st = 0; check_regs("R8 clear after collision");

    // Constrained random traffic, slot input held steady
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 5);
      v  = 8'($urandom);
      fid_in = 4'($urandom);
      case (op)
        0: begin wr(8'h02, v); m_en = v[4]; m_cpu = v[3:0]; end
        1: begin wr(8'h03, v); m_cs = v[3:0]; end
        2: begin wr(8'h05, v); end
        3: begin
          reg_addr = 8'h02; reg_wdata = v; reg_wr = v[0]; rstout_n = 0;
          @(posedge clk); @(negedge clk);
          reg_wr = 0; rstout_n = 1; m_en = 0; m_cpu = 0;
        end
        4: begin wr(8'($urandom_range(8, 255)), v); end
        default: idle(1);
      endcase
      check_outs("R1 R2 random outputs");
      rd(8'($urandom_range(0, 7)), d);
      chk("R3 random readback", d, exp_read(reg_addr));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule